// File: doc/BRIEF.md
# GPIO Edge Interrupt Unit

This unit watches a bank of synchronized GPIO input levels and turns single edges into sticky status bits. Each pin has its own enable, edge-select, status and wake-enable bit. One edge direction is armed per pin: a select bit of 0 arms the rising edge and 1 arms the falling edge. A detected edge sets the pin's status bit whether or not the pin is enabled. The status bit stays set until software writes a 1 to it.

Two combined outputs are produced. The interrupt line is asserted while any status bit is set whose enable bit is also set. The wake line is asserted while any status bit is set whose wake-enable bit is also set. Software reaches every control through a small word-addressed register port and can read back the live pin levels. With those levels it can re-arm the opposite edge when it needs to emulate both-edge sensing.

The bank holds up to 64 pins, split into a low word (pins 0–31) and a high word (pins 32–63). Bit positions at or above the configured pin count do not exist.

Top module: `gpio_edge_irq`

## Requirements
- R1: Byte offsets (address bits [1:0] ignored): enable 0x00/0x04, edge-select 0x08/0x0C, status 0x10/0x14, wake-enable 0x18/0x1C, live pin level 0x20/0x24. The first word of each pair holds pins 0–31 at bits 0–31. The second word holds pins 32–63 at bits 0–31. Any other offset reads zero.
- R2: With a select bit of 0 only a rising edge on the pin sets its status bit. With a select bit of 1 only a falling edge sets it. The opposite edge is ignored.
- R3: A detected edge sets the status bit even when the pin's enable bit is 0, and the interrupt output stays low for that pin.
- R4: Writing 1 to a status bit clears it; writing 0 leaves it as it was.
- R5: When an edge and a write-1 clear hit the same status bit in the same cycle, the bit is set afterwards.
- R6: irq_o is high exactly when some pin has both its status and enable bits set. It reflects register changes in the cycle after the write or edge.
- R7: wake_o is high exactly when some pin has both its status and wake-enable bits set.
- R8: Enable, edge-select and wake-enable bits take the written value per bit and keep it until that word is written again.
- R9: Changing an edge-select bit while the pin level is steady does not set the status bit.
- R10: Bits for pins at or above NUM_PINS read as zero and ignore writes. Writes to the pin-level words are ignored, and those words show the current pin_level.
- R11: After reset all stored bits are zero and irq_o and wake_o are low. No edge is taken in the first cycle after reset, so a pin that is high at reset release does not set status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 6 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_level | input | NUM_PINS | Synchronized pin levels |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | Combined wake request |

## Verification
An armed edge and a software write-1 clear can both target the same status bit in one clock cycle. The bench provokes this by changing the pin level and presenting the clear write in the same cycle. It then reads the status word and expects the bit to be set. Long random runs mix level changes with random writes to every word, so such collisions also occur on other bits. Each cycle and each readback is compared against a bench model that applies the clear first and the set after it.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int WORD_W   = 32;
    localparam int MAX_PINS = 64;
    localparam int ADDR_W   = 6;
    localparam int SEL_W    = 4;

    // word index = byte address [5:2]; low/high half share a kind
    typedef enum logic [SEL_W-1:0] {
        SEL_EN_LO  = 4'd0,
        SEL_EN_HI  = 4'd1,
        SEL_POL_LO = 4'd2,
        SEL_POL_HI = 4'd3,
        SEL_ST_LO  = 4'd4,
        SEL_ST_HI  = 4'd5,
        SEL_WK_LO  = 4'd6,
        SEL_WK_HI  = 4'd7,
        SEL_LVL_LO = 4'd8,
        SEL_LVL_HI = 4'd9
    } word_sel_e;

endpackage

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge #(
    parameter int NUM_PINS = 36
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_level,
    input  logic [NUM_PINS-1:0] polarity,
    output logic [NUM_PINS-1:0] edge_hit
);

    logic [NUM_PINS-1:0] prev_q;
    logic                primed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= pin_level;
            primed_q <= 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic rise_w;
        logic fall_w;
        assign rise_w      = pin_level[i] & ~prev_q[i];
        assign fall_w      = ~pin_level[i] & prev_q[i];
        assign edge_hit[i] = primed_q & (polarity[i] ? fall_w : rise_w);
    end

    AST_STEADY_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_level == prev_q) |-> (edge_hit == '0)); // R9

endmodule

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 36
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [NUM_PINS-1:0] enable,
    output logic [NUM_PINS-1:0] polarity,
    output logic [NUM_PINS-1:0] wake_en
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        localparam int WI = i / WORD_W;
        localparam int BI = i % WORD_W;
        localparam logic [SEL_W-1:0] S_EN  = SEL_W'(int'(SEL_EN_LO)  + WI);
        localparam logic [SEL_W-1:0] S_POL = SEL_W'(int'(SEL_POL_LO) + WI);
        localparam logic [SEL_W-1:0] S_WK  = SEL_W'(int'(SEL_WK_LO)  + WI);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                enable[i]   <= 1'b0;
                polarity[i] <= 1'b0;
                wake_en[i]  <= 1'b0;
            end else if (wr_en) begin
                if (wr_sel == S_EN)  enable[i]   <= wr_data[BI];
                if (wr_sel == S_POL) polarity[i] <= wr_data[BI];
                if (wr_sel == S_WK)  wake_en[i]  <= wr_data[BI];
            end
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(enable) && $stable(polarity) && $stable(wake_en))); // R8

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 36
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [NUM_PINS-1:0] edge_hit,
    output logic [NUM_PINS-1:0] status
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        localparam int WI = i / WORD_W;
        localparam int BI = i % WORD_W;
        localparam logic [SEL_W-1:0] S_ST = SEL_W'(int'(SEL_ST_LO) + WI);
        logic clr_w;
        assign clr_w = wr_en && (wr_sel == S_ST) && wr_data[BI];

        // set has priority over a simultaneous clear
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           status[i] <= 1'b0;
            else if (edge_hit[i]) status[i] <= 1'b1;
            else if (clr_w)       status[i] <= 1'b0;
        end
    end

    AST_SET_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status)) != '0) |-> ($past(edge_hit) != '0)); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((status & $past(edge_hit)) == $past(edge_hit))); // R5
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((status & $past(status)) == $past(status))); // R4

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 36
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_level,
    output logic                irq_o,
    output logic                wake_o
);

    logic [SEL_W-1:0]    sel_w;
    logic [1:0]          addr_unused;
    logic [NUM_PINS-1:0] enable_w;
    logic [NUM_PINS-1:0] polarity_w;
    logic [NUM_PINS-1:0] wake_en_w;
    logic [NUM_PINS-1:0] status_w;
    logic [NUM_PINS-1:0] edge_w;

    assign sel_w       = bus_addr[ADDR_W-1:2];
    assign addr_unused = bus_addr[1:0];

    gpio_irq_edge #(.NUM_PINS(NUM_PINS)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_level (pin_level),
        .polarity  (polarity_w),
        .edge_hit  (edge_w)
    );

    gpio_irq_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .wr_sel   (sel_w),
        .wr_data  (bus_wdata),
        .enable   (enable_w),
        .polarity (polarity_w),
        .wake_en  (wake_en_w)
    );

    gpio_irq_status #(.NUM_PINS(NUM_PINS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .wr_sel   (sel_w),
        .wr_data  (bus_wdata),
        .edge_hit (edge_w),
        .status   (status_w)
    );

    function automatic logic [MAX_PINS-1:0] pad_bank(input logic [NUM_PINS-1:0] v);
        logic [MAX_PINS-1:0] p;
        p = '0;
        p[NUM_PINS-1:0] = v;
        return p;
    endfunction

    logic [MAX_PINS-1:0] en_p, pol_p, st_p, wk_p, lvl_p;
    assign en_p  = pad_bank(enable_w);
    assign pol_p = pad_bank(polarity_w);
    assign st_p  = pad_bank(status_w);
    assign wk_p  = pad_bank(wake_en_w);
    assign lvl_p = pad_bank(pin_level);

    always_comb begin
        case (word_sel_e'(sel_w))
            SEL_EN_LO:  bus_rdata = en_p[31:0];
            SEL_EN_HI:  bus_rdata = en_p[63:32];
            SEL_POL_LO: bus_rdata = pol_p[31:0];
            SEL_POL_HI: bus_rdata = pol_p[63:32];
            SEL_ST_LO:  bus_rdata = st_p[31:0];
            SEL_ST_HI:  bus_rdata = st_p[63:32];
            SEL_WK_LO:  bus_rdata = wk_p[31:0];
            SEL_WK_HI:  bus_rdata = wk_p[63:32];
            SEL_LVL_LO: bus_rdata = lvl_p[31:0];
            SEL_LVL_HI: bus_rdata = lvl_p[63:32];
            default:    bus_rdata = '0;
        endcase
    end

    assign irq_o  = |(status_w & enable_w);
    assign wake_o = |(status_w & wake_en_w);

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (enable_w != '0)); // R6
    AST_WAKE_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (status_w != '0)); // R7

endmodule

// File: tb/gpio_edge_irq_tb.sv
module gpio_edge_irq_tb;

    localparam int NP = 36;
    localparam logic [63:0] VALID = (64'd1 << NP) - 64'd1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_level = '1;
    logic          irq_o, wake_o;

    always #4 clk = ~clk;

    gpio_edge_irq #(.NUM_PINS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_level(pin_level),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    int checks = 0;
    int errors = 0;
    logic [63:0] m_en = '0, m_pol = '0, m_st = '0, m_wk = '0, m_prev = '0, cur = '1;
    bit m_primed = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] det_f(input logic [63:0] prev, input logic [63:0] pin,
                                          input logic [63:0] pol);
        return VALID & ((pol & prev & ~pin) | (~pol & ~prev & pin));
    endfunction

    function automatic logic [31:0] exp_word(input logic [3:0] idx);
        logic [63:0] v;
        case (idx[3:1])
            3'd0: v = m_en;
            3'd1: v = m_pol;
            3'd2: v = m_st;
            3'd3: v = m_wk;
            3'd4: v = cur & VALID;
            default: v = '0;
        endcase
        if (idx > 4'd9) v = '0;
        return idx[0] ? v[63:32] : v[31:0];
    endfunction

    task automatic step(input logic [63:0] pins, input bit wr, input logic [5:0] a,
                        input logic [31:0] d);
        logic [63:0] det, clr, d64;
        @(negedge clk);
        cur = pins;
        pin_level = pins[NP-1:0];
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        det = m_primed ? det_f(m_prev, pins & VALID, m_pol) : '0;
        clr = '0;
        if (wr) begin
            d64 = a[2] ? {d, 32'h0} : {32'h0, d};
            case (a[5:3])
                3'd0: m_en  = a[2] ? {d & VALID[63:32], m_en[31:0]}  : {m_en[63:32], d};
                3'd1: m_pol = a[2] ? {d & VALID[63:32], m_pol[31:0]} : {m_pol[63:32], d};
                3'd2: clr   = d64 & VALID;
                3'd3: m_wk  = a[2] ? {d & VALID[63:32], m_wk[31:0]}  : {m_wk[63:32], d};
                default: ;
            endcase
        end
        m_st = ((m_st & ~clr) | det) & VALID;
        m_prev = pins & VALID;
        m_primed = 1'b1;
        #1 bus_wr = 1'b0;
        #1;
        chk("R6 irq_o", {31'b0, irq_o}, {31'b0, |(m_st & m_en)});
        chk("R7 wake_o", {31'b0, wake_o}, {31'b0, |(m_st & m_wk)});
    endtask

    task automatic rd(input logic [5:0] a, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1 chk(tag, bus_rdata, exp_word(a[5:2]));
    endtask

    bit done = 1'b0;

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        m_prev = cur & VALID; m_primed = 1'b1;
        #2;
        chk("R11 irq_o after reset", {31'b0, irq_o}, 32'h0);
        chk("R11 wake_o after reset", {31'b0, wake_o}, 32'h0);
        for (int w = 0; w < 10; w++) rd(6'(w * 4), "R11 reset readback");
        rd(6'h10, "R11 high pin at release sets no status");

        step('0, 0, 6'h0, 0);
        rd(6'h10, "R2 falling ignored under rising select");

        step(cur, 1, 6'h00, 32'hA5A5_00FF);
        rd(6'h00, "R8 enable low word");
        step(cur, 1, 6'h04, 32'hFFFF_FFFF);
        rd(6'h04, "R10 enable high pad bits");
        chk("R10 enable high value", exp_word(4'd1), 32'h0000_000F);
        step(cur, 1, 6'h20, 32'hDEAD_BEEF);
        rd(6'h20, "R10 level word ignores write");
        rd(6'h2C, "R1 unmapped word reads zero");
        step(cur, 1, 6'h00, 32'h0);
        step(cur, 1, 6'h04, 32'h0);
        step(cur, 1, 6'h08, 32'h0000_0002);

        step(64'h3, 0, 0, 0);
        rd(6'h10, "R2 rising on select 0 only");
        chk("R3 masked status set", exp_word(4'd4), 32'h1);
        step(64'h0, 0, 0, 0);
        rd(6'h10, "R2 falling on select 1");
        step(cur, 1, 6'h10, 32'h3);
        rd(6'h10, "R4 write one clears");
        step(cur, 1, 6'h08, 32'hFFFF_FFFF);
        step(cur, 1, 6'h08, 32'h0000_0001);
        rd(6'h10, "R9 select change makes no edge");
        step(64'h1, 0, 0, 0);
        step(64'h0, 0, 0, 0);
        rd(6'h10, "R2 falling on pin0");
        step(cur, 1, 6'h10, 32'h0);
        rd(6'h10, "R4 write zero keeps");
        step(cur, 1, 6'h00, 32'h1);
        chk("R6 irq with enable", {31'b0, irq_o}, 32'h1);
        step(cur, 1, 6'h18, 32'h1);
        chk("R7 wake with wake-enable", {31'b0, wake_o}, 32'h1);
        step(cur, 1, 6'h10, 32'h1);
        rd(6'h10, "R4 cleared before collision");
        step(64'h1, 0, 0, 0);
        step(64'h0, 1, 6'h10, 32'h1);
        rd(6'h10, "R5 set wins over clear");
        chk("R5 bit kept", exp_word(4'd4), 32'h1);
        step(64'h2_0000_0000, 0, 0, 0);
        rd(6'h14, "R1 high word pin 33 status");

        for (int n = 0; n < 600; n++) begin
            logic [63:0] p;
            bit wr;
            logic [3:0] idx;
            p   = {$urandom, $urandom};
            wr  = ($urandom % 2) == 1;
            idx = 4'($urandom % 10);
            step(p, wr, {idx, 2'b00}, $urandom);
            if (n % 3 == 0) rd({4'($urandom % 12), 2'($urandom)}, "R1 random readback");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule